// File: doc/BRIEF.md
# Saturating Double-to-Integer Converter

This block turns a 64-bit binary floating-point value into an integer of 32 or 64 bits, signed or unsigned. Two control inputs choose the result width and signedness for each sample. The fractional part is discarded, so results are truncated toward zero. Values whose magnitude does not fit the chosen integer are clamped to the nearest representable limit. Every special class has a fixed answer, so a result is always defined.

The input uses the usual double layout. Bit 63 is the sign. Bits 62:52 hold the biased exponent, with a bias of 1023. Bits 51:0 hold the fraction. A sample is accepted when `in_valid` is high. The result appears on a registered 64-bit output one clock later, together with `out_valid`. A 32-bit result is widened to the full 64 bits: by sign extension in signed mode and by zero extension in unsigned mode.

Top module: `fp2int_sat_conv`

## Requirements
- R1: The conversion has a latency of exactly one clock.
  - `out_valid` equals the `in_valid` of the previous cycle.
  - `out_int` is loaded only when `in_valid` is high and otherwise holds its value.
  - Reset clears both `out_int` and `out_valid` to 0.
- R2: The following inputs give 0 in every width and signedness mode:
  - a zero of either sign;
  - a NaN, meaning exponent field all ones with a nonzero fraction.
- R3: Any finite input with magnitude below 1 gives 0. This covers subnormals (exponent field 0, nonzero fraction) and any unbiased exponent below 0.
- R4: In unsigned mode (`sel_signed`=0), any input with the sign bit set gives 0. This includes negative infinity and negative values of any size.
- R5: In signed mode with width W, an infinity or an unbiased exponent greater than W-2 saturates:
  - to 2^(W-1)-1 when the sign bit is clear;
  - to -2^(W-1) when the sign bit is set.
- R6: In unsigned mode with width W, positive infinity or an unbiased exponent greater than W-1 gives 2^W-1.
- R7: Any other finite input gives the integer part of its magnitude, truncated toward zero. In signed mode this value is negated (two's complement) when the sign bit is set.
- R8: `sel_wide`=1 selects W=64 and `sel_wide`=0 selects W=32. A 32-bit signed result is sign-extended into `out_int`. A 32-bit unsigned result is zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept `in_bits` this cycle |
| in_bits | input | 64 | Double value: sign 63, biased exponent 62:52, fraction 51:0 |
| sel_signed | input | 1 | 1 = signed result, 0 = unsigned result |
| sel_wide | input | 1 | 1 = 64-bit result, 0 = 32-bit result extended to 64 |
| out_valid | output | 1 | `out_int` holds a newly converted result |
| out_int | output | 64 | Converted integer |

## Verification
Each accepted sample is converted on the first rising edge after it is presented. Its result and `out_valid` are therefore due one cycle later and stay put while `in_valid` is low.

The bench drives inputs on a falling edge and samples the outputs on the next falling edge, so every comparison falls exactly on the due cycle. Hold checks change `in_bits` with `in_valid` low and confirm that the output has not moved a cycle later.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

  // Decoded class of a floating-point operand
  typedef enum logic [2:0] {
    FC_ZERO,
    FC_SUB,
    FC_NORM,
    FC_INF,
    FC_NAN
  } fp_class_e;

endpackage

// File: rtl/fp2i_classify.sv
module fp2i_classify
  import fp2int_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0]  bits_i,
  output logic                   sign_o,
  output fp_class_e              cls_o,
  output logic signed [EXP_W+1:0] uexp_o,
  output logic [FRAC_W:0]        mant_o
);
  localparam int TOP  = EXP_W + FRAC_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [EXP_W+1:0] BIAS_S = (EXP_W+2)'(BIAS);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_full, frac_zero;

  assign sign_o    = bits_i[TOP];
  assign exp_f     = bits_i[TOP-1:FRAC_W];
  assign frac_f    = bits_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_full  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  // Unbiased exponent; one extra bit on each side so it never wraps
  assign uexp_o = $signed({2'b00, exp_f}) - BIAS_S;

  // Significand with the hidden leading one restored
  assign mant_o = {1'b1, frac_f};

  always_comb begin
    if (exp_full)       cls_o = frac_zero ? FC_INF : FC_NAN;
    else if (exp_zero)  cls_o = frac_zero ? FC_ZERO : FC_SUB;
    else                cls_o = FC_NORM;
  end
endmodule

// File: rtl/fp2i_magnitude.sv
module fp2i_magnitude #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  logic [FRAC_W:0]         mant_i,
  input  logic signed [EXP_W+1:0] uexp_i,
  output logic [INT_W-1:0]        mag_o
);
  localparam int PAD = INT_W - FRAC_W - 1;

  // Move the binary point from FRAC_W to the unbiased exponent
  function automatic logic [INT_W-1:0] align_mant(
    input logic [FRAC_W:0] m,
    input int              ue
  );
    logic [INT_W-1:0] ext;
    ext = {{PAD{1'b0}}, m};
    if (ue < 0)              return '0;
    else if (ue >= INT_W)    return '0;
    else if (ue >= FRAC_W)   return ext << (ue - FRAC_W);
    else                     return ext >> (FRAC_W - ue);
  endfunction

  int uexp_int;
  assign uexp_int = int'(uexp_i);
  assign mag_o    = align_mant(mant_i, uexp_int);

  // The leading one of the integer magnitude sits at bit position uexp
  always_comb begin
    if (uexp_int >= 0 && uexp_int < INT_W)
      AST_LEAD_ONE: assert ((mag_o >> uexp_int) == INT_W'(1)); // R7
  end
endmodule

// File: rtl/fp2i_select.sv
module fp2i_select
  import fp2int_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic                    sign_i,
  input  fp_class_e               cls_i,
  input  logic signed [EXP_W+1:0] uexp_i,
  input  logic [INT_W-1:0]        mag_i,
  input  logic                    want_signed_i,
  input  logic                    want_wide_i,
  output logic                    force_zero_o,
  output logic                    sat_top_o,
  output logic                    sat_bot_o,
  output logic [INT_W-1:0]        result_o
);
  localparam logic [INT_W-1:0] SMAX_WIDE = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] UMAX_WIDE = '1;
  localparam logic [INT_W-1:0] SMAX_NAR  = INT_W'({(NARROW_W-1){1'b1}});
  localparam logic [INT_W-1:0] UMAX_NAR  = INT_W'({NARROW_W{1'b1}});

  // Upper clamp for the chosen width and signedness
  function automatic logic [INT_W-1:0] upper_limit(input logic s, input logic w);
    if (s) return w ? SMAX_WIDE : SMAX_NAR;
    else   return w ? UMAX_WIDE : UMAX_NAR;
  endfunction

  // Largest unbiased exponent that still fits the chosen integer
  function automatic int exp_limit(input logic s, input logic w);
    int width;
    width = w ? INT_W : NARROW_W;
    return s ? width - 2 : width - 1;
  endfunction

  int  uexp_int;
  int  lim;
  logic too_big, neg_signed;

  assign uexp_int   = int'(uexp_i);
  assign lim        = exp_limit(want_signed_i, want_wide_i);
  assign too_big    = (cls_i == FC_INF) || (cls_i == FC_NORM && uexp_int > lim);
  assign neg_signed = want_signed_i && sign_i;

  always_comb begin
    force_zero_o = (cls_i == FC_NAN) || (cls_i == FC_ZERO) || (cls_i == FC_SUB)
                || (cls_i == FC_NORM && uexp_int < 0)
                || (!want_signed_i && sign_i);
    sat_top_o = !force_zero_o && too_big && !neg_signed;
    sat_bot_o = !force_zero_o && too_big && neg_signed;
  end

  always_comb begin
    if (force_zero_o)    result_o = '0;
    else if (sat_top_o)  result_o = upper_limit(want_signed_i, want_wide_i);
    else if (sat_bot_o)  result_o = ~upper_limit(1'b1, want_wide_i);
    else if (neg_signed) result_o = -mag_i;
    else                 result_o = mag_i;
  end

  always_comb begin
    AST_ONE_RULE: assert ($onehot0({force_zero_o, sat_top_o, sat_bot_o})); // R5
  end
endmodule

// File: rtl/fp2int_sat_conv.sv
module fp2int_sat_conv
  import fp2int_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     in_bits,
  input  logic                      sel_signed,
  input  logic                      sel_wide,
  output logic                      out_valid,
  output logic [INT_W-1:0]          out_int
);
  localparam int TOP = EXP_W + FRAC_W;

  logic                    sign_w;
  fp_class_e               cls_w;
  logic signed [EXP_W+1:0] uexp_w;
  logic [FRAC_W:0]         mant_w;
  logic [INT_W-1:0]        mag_w;
  logic [INT_W-1:0]        result_w;
  logic                    force_zero_w, sat_top_w, sat_bot_w;

  fp2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .bits_i (in_bits),
    .sign_o (sign_w),
    .cls_o  (cls_w),
    .uexp_o (uexp_w),
    .mant_o (mant_w)
  );

  fp2i_magnitude #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_magnitude (
    .mant_i (mant_w),
    .uexp_i (uexp_w),
    .mag_o  (mag_w)
  );

  fp2i_select #(.EXP_W(EXP_W), .INT_W(INT_W), .NARROW_W(NARROW_W)) u_select (
    .sign_i        (sign_w),
    .cls_i         (cls_w),
    .uexp_i        (uexp_w),
    .mag_i         (mag_w),
    .want_signed_i (sel_signed),
    .want_wide_i   (sel_wide),
    .force_zero_o  (force_zero_w),
    .sat_top_o     (sat_top_w),
    .sat_bot_o     (sat_bot_w),
    .result_o      (result_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_int   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_int <= result_w;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_int)); // R1
  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (&in_bits[TOP-1:FRAC_W]) && (|in_bits[FRAC_W-1:0]) |=> out_int == '0); // R2
  AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !sel_signed && in_bits[TOP] |=> out_int == '0); // R4
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !sel_wide && !sel_signed |=> out_int[INT_W-1:NARROW_W] == '0); // R8
  AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !sel_wide && sel_signed |=>
      (out_int[INT_W-1:NARROW_W-1] == '0) || (&out_int[INT_W-1:NARROW_W-1])); // R8
endmodule

// File: tb/fp2int_sat_conv_tb.sv
`timescale 1ns/1ps
module fp2int_sat_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_bits = '0;
  logic        sel_signed = 1'b0;
  logic        sel_wide = 1'b0;
  logic        out_valid;
  logic [63:0] out_int;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  fp2int_sat_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .sel_signed(sel_signed), .sel_wide(sel_wide),
    .out_valid(out_valid), .out_int(out_int)
  );

  always #4 clk = ~clk;

  // Reference built from the requirement text: scale by 2^ue in wide arithmetic
  function automatic logic [63:0] expect_conv(input logic [63:0] b, input bit sgn, input bit wide);
    int          e, ue, w;
    logic        s;
    logic [51:0] f;
    logic [127:0] big;
    logic [63:0] mag, smax, smin, umax;
    e = int'(b[62:52]); ue = e - 1023; s = b[63]; f = b[51:0];
    w = wide ? 64 : 32;
    smax = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    smin = wide ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
    umax = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    if (e == 2047 && f != 0) return 64'd0;                          // R2 NaN
    if (e == 2047) return sgn ? (s ? smin : smax) : (s ? 64'd0 : umax); // R5 R6 R4
    if (e == 0) return 64'd0;                                        // R2 R3
    if (ue < 0) return 64'd0;                                        // R3
    if (!sgn && s) return 64'd0;                                     // R4
    if (sgn && ue > w - 2) return s ? smin : smax;                   // R5
    if (!sgn && ue > w - 1) return umax;                             // R6
    big = {75'd0, 1'b1, f} << ue;
    big = big >> 52;
    mag = big[63:0];
    return (sgn && s) ? -mag : mag;                                  // R7
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge; the result is due on the next falling edge
  task automatic convert(input logic [63:0] b, input bit sgn, input bit wide, input string req);
    @(negedge clk);
    in_bits = b; sel_signed = sgn; sel_wide = wide; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_int, expect_conv(b, sgn, wide));
  endtask

  task automatic all_modes(input logic [63:0] b, input string req);
    for (int m = 0; m < 4; m++) convert(b, m[0], m[1], req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [63:0] r;
    seed = $urandom(32'd2024);
    #3;
    check("R1 reset out_int", out_int, 64'd0);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    all_modes(64'h0000_0000_0000_0000, "R2 +zero");
    all_modes(64'h8000_0000_0000_0000, "R2 -zero");
    all_modes(64'h7FF8_0000_0000_0000, "R2 qNaN");
    all_modes(64'hFFF0_0000_0000_0001, "R2 neg NaN");
    all_modes(64'h3FE0_0000_0000_0000, "R3 half");
    all_modes(64'h0000_0000_0000_0001, "R3 subnormal");
    all_modes(64'hBFEF_FFFF_FFFF_FFFF, "R3 neg below one");
    all_modes(64'hC1E0_0000_0000_0000, "R4 -2^31");
    all_modes(64'hFFF0_0000_0000_0000, "R5 -inf");
    all_modes(64'h7FF0_0000_0000_0000, "R6 +inf");
    all_modes(64'h41E0_0000_0000_0000, "R5 2^31");
    all_modes(64'h41DF_FFFF_FFC0_0000, "R7 2^31-1");
    all_modes(64'h41F0_0000_0000_0000, "R6 2^32");
    all_modes(64'h43E0_0000_0000_0000, "R5 2^63");
    all_modes(64'h43F0_0000_0000_0000, "R6 2^64");
    all_modes(64'hC3E0_0000_0000_0000, "R5 -2^63");
    all_modes(64'hBFF8_0000_0000_0000, "R7 -1.5");

    // Literal expectations that do not go through the reference
    convert(64'h408F_4000_0000_0000, 1'b1, 1'b1, "R7 1000.0");
    check("R7 literal 1000", out_int, 64'd1000);
    convert(64'hBFF8_0000_0000_0000, 1'b1, 1'b0, "R8 -1.5 narrow");
    check("R8 literal -1 sign-extended", out_int, 64'hFFFF_FFFF_FFFF_FFFF);
    convert(64'h41E0_0000_0000_0000, 1'b0, 1'b0, "R8 2^31 unsigned narrow");
    check("R8 literal 2^31 zero-extended", out_int, 64'h0000_0000_8000_0000);

    // Hold behaviour: in_valid low, new bits presented, output unchanged
    convert(64'h4059_0000_0000_0000, 1'b1, 1'b1, "R7 100.0");
    begin
      logic [63:0] held;
      held = out_int;
      @(negedge clk);
      in_bits = 64'h7FF0_0000_0000_0000; in_valid = 1'b0;
      @(negedge clk);
      check("R1 hold value", out_int, held);
      check("R1 valid low", {63'd0, out_valid}, 64'd0);
    end

    for (int i = 0; i < 3000; i++) begin
      r = {$urandom, $urandom};
      if (i % 4 != 0) r[62:52] = 11'(1018 + $urandom_range(0, 72));
      convert(r, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule